// File: doc/BRIEF.md
# Phase-Shared Register File

This block is a small register file that takes one write and one read in every system clock cycle while its storage array has only one address port. Each system cycle is cut into two halves. In the first half the array port carries the write address, and a pending write is committed on the edge that closes that half. In the second half the port carries the read address, and the word it selects is loaded into a read-data register on the edge that closes the second half.

Two ways of producing the halves are offered by a parameter. In dual-edge mode the system clock drives the block directly: writes land on its rising edge and reads are captured on its falling edge. In double-rate mode the clock input runs at twice the system rate. The block alternates write and read slots on successive rising edges, so the array must complete an access in half a system cycle. All request inputs are held for one full system cycle. A read of the address being written in the same cycle returns the new word.

Top module: `tmrf_regfile`

## Requirements
- R1: Every system cycle performs one write slot followed by one read slot, so a read of any address is delivered in the same cycle as a write to another address.
- R2: When `wr_en` is high at the write edge (rising clock edge in dual-edge mode, the first fast edge of the cycle in double-rate mode), `wr_data` is stored at `wr_addr`.
- R3: At the read edge (falling clock edge in dual-edge mode, the second fast edge of the cycle in double-rate mode) the word at `rd_addr` is loaded into `rd_data`.
- R4: When `rd_addr` equals `wr_addr` and `wr_en` is high in the same cycle, `rd_data` returns the newly written word.
- R5: When `wr_en` is low, no entry of the array changes, and the read slot of that cycle still completes.
- R6: While `rst` is high at a read edge, `rd_data` is cleared to zero; array contents are left untouched by reset.
- R7: In double-rate mode the first fast edge after `rst` is released is a write slot and slots then alternate, giving cycle-for-cycle the same `rd_data` as dual-edge mode.
- R8: `rd_data` is an edge-triggered register and never follows the array: a change of `rd_addr` or a write between two read edges does not change `rd_data`.
- R9: Depth (default 16) and word width (default 32) are parameters; every address from 0 to depth-1 holds its own word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (dual-edge mode) or clock at twice the system rate (double-rate mode) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Commit `wr_data` at `wr_addr` in this cycle's write slot |
| wr_addr | input | $clog2(DEPTH) | Write address |
| wr_data | input | WIDTH | Word to write |
| rd_addr | input | $clog2(DEPTH) | Read address |
| rd_data | output | WIDTH | Registered read word, loaded at each read edge |

## Verification
Two instances, one per mode, receive identical stimulus and are compared against a reference array kept in the bench. Reads of an address different from the one written tell the write slot apart from the read slot, while reads of the address just written show whether the write lands before the read. Cycles with the write enable low but garbage on the write bus show whether a disabled write leaks into the array, and a full fill followed by a reverse-order readback separates every address. Changing the read address between edges and sampling mid-cycle distinguishes a true edge register from a transparent path.

// File: rtl/tmrf_pkg.sv
package tmrf_pkg;

    // How the write and read halves of a system cycle are produced
    typedef enum logic [0:0] {
        MODE_DUAL_EDGE   = 1'b0,
        MODE_DOUBLE_RATE = 1'b1
    } tmrf_mode_e;

    // Address width for a given depth, never below one bit
    function automatic int addr_w(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/tmrf_phase_gen.sv
module tmrf_phase_gen #(
    parameter tmrf_pkg::tmrf_mode_e MODE = tmrf_pkg::MODE_DUAL_EDGE
) (
    input  logic clk,
    input  logic rst,
    output logic rd_phase
);
    generate
        if (MODE == tmrf_pkg::MODE_DUAL_EDGE) begin : g_dual
            // Toggle pair: rising edge flips, falling edge follows.
            // Differ during the high half (read half), equal during the low half.
            logic pos_t;
            logic neg_t;

            always_ff @(posedge clk) begin
                if (rst) pos_t <= 1'b0;
                else     pos_t <= ~pos_t;
            end

            always_ff @(negedge clk) begin
                neg_t <= pos_t;
            end

            assign rd_phase = pos_t ^ neg_t;

            // R1: every rising edge closes a write half
            p_write_half_r1: assert property (@(posedge clk) disable iff (rst)
                !rd_phase)
                else $error("rising edge seen outside write half");
        end else begin : g_double
            // One slot per fast edge, write slot first after reset
            logic wr_slot;

            always_ff @(posedge clk) begin
                if (rst) wr_slot <= 1'b1;
                else     wr_slot <= ~wr_slot;
            end

            assign rd_phase = ~wr_slot;

            // R7: slots strictly alternate
            p_slot_alt_r7: assert property (@(posedge clk) disable iff (rst)
                rd_phase |=> !rd_phase)
                else $error("two read slots in a row");
            p_slot_alt_w_r7: assert property (@(posedge clk) disable iff (rst)
                !rd_phase |=> rd_phase)
                else $error("two write slots in a row");
        end
    endgenerate
endmodule

// File: rtl/tmrf_array.sv
module tmrf_array #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int AW   = tmrf_pkg::addr_w(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    // Single address port: one address serves both write and read
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/tmrf_capture.sv
module tmrf_capture #(
    parameter tmrf_pkg::tmrf_mode_e MODE = tmrf_pkg::MODE_DUAL_EDGE,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_phase,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (MODE == tmrf_pkg::MODE_DUAL_EDGE) begin : g_neg
            // Opposite edge to the array write clock, never transparent
            always_ff @(negedge clk) begin
                if (rst)           q <= '0;
                else if (rd_phase) q <= d;
            end

            // R6: reset clears the read register
            p_rst_clear_r6: assert property (@(negedge clk)
                rst |=> (q == '0))
                else $error("read register not cleared by reset");
            // R3: read edge loads the array word
            p_capture_r3: assert property (@(negedge clk) disable iff (rst)
                rd_phase |=> (q == $past(d)))
                else $error("read register missed array word");
        end else begin : g_pos
            always_ff @(posedge clk) begin
                if (rst)           q <= '0;
                else if (rd_phase) q <= d;
            end

            p_rst_clear_r6: assert property (@(posedge clk)
                rst |=> (q == '0))
                else $error("read register not cleared by reset");
            p_capture_r3: assert property (@(posedge clk) disable iff (rst)
                rd_phase |=> (q == $past(d)))
                else $error("read register missed array word");
            // R8: held through the write slot
            p_hold_r8: assert property (@(posedge clk) disable iff (rst)
                !rd_phase |=> $stable(q))
                else $error("read register changed in write slot");
        end
    endgenerate
endmodule

// File: rtl/tmrf_regfile.sv
module tmrf_regfile #(
    parameter tmrf_pkg::tmrf_mode_e MODE = tmrf_pkg::MODE_DUAL_EDGE,
    parameter int DEPTH = 16,
    parameter int WIDTH = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [WIDTH-1:0]         rd_data
);
    localparam int AW = tmrf_pkg::addr_w(DEPTH);

    typedef struct packed {
        logic             en;
        logic [AW-1:0]    addr;
        logic [WIDTH-1:0] data;
    } port_req_t;

    logic             rd_phase;
    port_req_t        arr_req;
    logic [WIDTH-1:0] arr_rdata;

    tmrf_phase_gen #(.MODE(MODE)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .rd_phase (rd_phase)
    );

    // Shared port: write request in the write half, read address otherwise
    always_comb begin
        arr_req.en   = wr_en & ~rd_phase;
        arr_req.addr = rd_phase ? rd_addr : wr_addr;
        arr_req.data = wr_data;
    end

    tmrf_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_arr (
        .clk   (clk),
        .we    (arr_req.en),
        .addr  (arr_req.addr),
        .wdata (arr_req.data),
        .rdata (arr_rdata)
    );

    tmrf_capture #(.MODE(MODE), .WIDTH(WIDTH)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .rd_phase (rd_phase),
        .d        (arr_rdata),
        .q        (rd_data)
    );

    // R2: an enabled write slot leaves the word in the array
    p_write_commit_r2: assert property (@(posedge clk) disable iff (rst)
        arr_req.en |=> (u_arr.mem[$past(arr_req.addr)] == $past(arr_req.data)))
        else $error("write not committed");
    // R5: a write slot with the enable low leaves the addressed word alone
    p_no_write_r5: assert property (@(posedge clk) disable iff (rst)
        (!rd_phase && !wr_en) |=>
            (u_arr.mem[$past(arr_req.addr)] == $past(u_arr.mem[arr_req.addr])))
        else $error("disabled write changed array");
endmodule

// File: tb/tmrf_regfile_tb.sv
`timescale 1ns/1ps
module tmrf_regfile_tb;
    localparam int DEPTH = 16;
    localparam int WIDTH = 32;
    localparam int AW    = $clog2(DEPTH);

    typedef struct packed {
        logic             we;
        logic [AW-1:0]    wa;
        logic [WIDTH-1:0] wd;
        logic [AW-1:0]    ra;
        logic [3:0]       req;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 4'd0,  32'hA0A0_0001, 4'd0,  4'd4},  // same address
        '{1'b1, 4'd1,  32'h1111_2222, 4'd0,  4'd1},  // read other address
        '{1'b1, 4'd15, 32'hF0F0_F0F0, 4'd1,  4'd1},
        '{1'b0, 4'd1,  32'hDEAD_BEEF, 4'd1,  4'd5},  // disabled write
        '{1'b1, 4'd15, 32'h0BAD_CAFE, 4'd15, 4'd4},  // overwrite, same address
        '{1'b0, 4'd0,  32'hFFFF_FFFF, 4'd0,  4'd5},
        '{1'b1, 4'd7,  32'h0000_0000, 4'd15, 4'd2},
        '{1'b1, 4'd8,  32'hFFFF_FFFF, 4'd7,  4'd2},
        '{1'b1, 4'd8,  32'h1234_5678, 4'd8,  4'd4},
        '{1'b0, 4'd8,  32'h5555_AAAA, 4'd8,  4'd3}
    };

    logic clk = 1'b0;
    logic clk2x = 1'b1;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [WIDTH-1:0] rd_dual, rd_dbl;

    always #5   clk   = ~clk;
    always #2.5 clk2x = ~clk2x;

    tmrf_regfile #(.MODE(tmrf_pkg::MODE_DUAL_EDGE), .DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_dual)
    );

    tmrf_regfile #(.MODE(tmrf_pkg::MODE_DOUBLE_RATE), .DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut2x (
        .clk(clk2x), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_dbl)
    );

    int total = 0;
    int bad = 0;
    logic [WIDTH-1:0] ref_mem [DEPTH];
    logic             ref_ok  [DEPTH];

    task automatic chk(input string tag, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Entered at falling edge + 2 ns; returns at the next falling edge + 2 ns
    task automatic run_cycle(input logic we, input logic [AW-1:0] wa,
                             input logic [WIDTH-1:0] wd, input logic [AW-1:0] ra,
                             input string tag);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        if (we) begin
            ref_mem[wa] = wd;
            ref_ok[wa]  = 1'b1;
        end
        @(negedge clk); #1;
        if (ref_ok[ra]) begin
            chk(tag, rd_dual, ref_mem[ra]);
            chk("R7", rd_dbl, ref_mem[ra]);
        end
        #1;
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_ok[i] = 1'b0;

        // Reset state (R6)
        repeat (3) @(negedge clk);
        #1;
        chk("R6", rd_dual, '0);
        chk("R6", rd_dbl, '0);
        #1 rst = 1'b0;

        // Vector table
        for (int v = 0; v < NVEC; v++)
            run_cycle(VECS[v].we, VECS[v].wa, VECS[v].wd, VECS[v].ra,
                      $sformatf("R%0d", VECS[v].req));

        // R8: no transparency between read edges
        begin
            logic [WIDTH-1:0] held;
            held = ref_mem[8];
            wr_en = 1'b1; wr_addr = 4'd8; wr_data = 32'h7777_0000; rd_addr = 4'd1;
            ref_mem[8] = 32'h7777_0000;
            @(posedge clk); #1;
            chk("R8", rd_dual, held);
            chk("R8", rd_dbl, held);
            @(negedge clk); #1;
            chk("R3", rd_dual, ref_mem[1]);
            chk("R7", rd_dbl, ref_mem[1]);
            #1;
        end

        // R9: fill every address with same-address reads, then read back reversed
        for (int i = 0; i < DEPTH; i++)
            run_cycle(1'b1, AW'(i), 32'hA500_0000 ^ (32'(i) * 32'h0101_0101), AW'(i), "R4");
        for (int i = 0; i < DEPTH; i++)
            run_cycle(1'b0, AW'(i), 32'hFFFF_0000, AW'(DEPTH - 1 - i), "R9");

        // R5: garbage on the write bus with enable low, read back every address
        for (int i = 0; i < DEPTH; i++)
            run_cycle(1'b0, AW'(DEPTH - 1 - i), ~32'(i), AW'(DEPTH - 1 - i), "R5");

        // R6: reset in mid-run clears the output, R7: realignment after release
        rst = 1'b1; wr_en = 1'b0;
        @(negedge clk); #1;
        chk("R6", rd_dual, '0);
        chk("R6", rd_dbl, '0);
        #1 rst = 1'b0;
        run_cycle(1'b1, 4'd3, 32'hC0DE_0003, 4'd3, "R4");
        run_cycle(1'b1, 4'd4, 32'hC0DE_0004, 4'd3, "R1");
        run_cycle(1'b0, 4'd0, 32'h0, 4'd4, "R2");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule